// File: doc/BRIEF.md
# Optical-Black Clamp Feedback Controller

This block closes the digital half of a black-level clamp loop around a 12-bit converter. Each time the optical-black pulse becomes active, it measures the black level by averaging eight converter codes taken from a fixed window that starts a few clocks after the pulse edge. It compares that measurement with a programmed clamp target and nudges a signed correction word. An external current DAC turns that word into charge on the feedback capacitor. The correction is updated once per evaluated line.

After the gain code changes, the black level moves by a large amount. The gain-setting logic signals this with a one-clock strobe. The controller then switches to a fast-acquisition mode in which the loop step is multiplied by a selectable power of two. It returns to the normal step only after the error has stayed within a small band for a selectable number of consecutive evaluations. An optional mode averages four line measurements before each evaluation, which gives a quieter but slower loop.

Top module: `blk_clamp_loop`

## Requirements
- R1: During reset and on the first cycle after reset, `corr_o` is 0, `fast_o` is 0 and `update_o` is 0.
- R2: A clock edge at which the optical-black input is active, and was not active at the previous edge, is called edge 0. The converter codes taken at edges 5 through 12 after edge 0 are summed, and the sum shifted right by 3 is the line's black level. Codes taken at any other edge have no effect.
- R3: When `ob_low_act_i` is 0, a high level on `ob_pulse_i` is active. When `ob_low_act_i` is 1, a low level is active.
- R4: An active edge that arrives while a window is still open is ignored. Each window yields exactly one measurement.
- R5: The clamp target is 56 + 8 × `target_sel_i` (56 for 0, 128 for 9, 304 for 31). The error is the target minus the evaluated black level. An error of 0 leaves `corr_o` unchanged.
- R6: In normal mode the step is the error shifted right arithmetically by 4, so it rounds toward minus infinity. The step is added to `corr_o`. `update_o` pulses for one cycle and `corr_o` takes its new value at the second clock edge after the last window sample. `corr_o` changes on no other cycle.
- R7: `corr_o` saturates at 2047 and −2048 instead of wrapping.
- R8: A one-cycle `gain_chg_i` strobe sets `fast_o` from the next cycle. While `fast_o` is 1, the step is multiplied by 2, 4, 8 or 16 when `fast_mult_sel_i` is 0, 1, 2 or 3.
- R9: While fast, any evaluation whose absolute error exceeds 64 keeps `fast_o` at 1 and restarts the exit count from zero.
- R10: While fast, once 1, 2, 4 or 8 consecutive evaluations (for `exit_lines_sel_i` = 0, 1, 2 or 3) have an absolute error of 64 or less, `fast_o` returns to 0. The last of these evaluations still uses the multiplied step.
- R11: With `avg4_en_i` set, only every fourth line measurement triggers an evaluation. That evaluation uses the sum of the four measurements shifted right by 2, and `corr_o` stays unchanged after the other three.
- R12: A `gain_chg_i` strobe in the same cycle as an evaluation that would end fast mode keeps `fast_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 12 | Converter output code |
| ob_pulse_i | input | 1 | Optical-black pulse |
| ob_low_act_i | input | 1 | 1 selects an active-low optical-black pulse |
| gain_chg_i | input | 1 | One-cycle strobe when the gain code changes |
| target_sel_i | input | 5 | Clamp target setting |
| fast_mult_sel_i | input | 2 | Fast-mode step multiplier select |
| exit_lines_sel_i | input | 2 | Number of calm evaluations needed to leave fast mode |
| avg4_en_i | input | 1 | Average four lines per evaluation |
| corr_o | output | 12 | Signed correction word to the current DAC |
| fast_o | output | 1 | Fast-acquisition mode active |
| update_o | output | 1 | One-cycle pulse when `corr_o` was updated |

## Verification
The embedded assertions check several properties on every cycle. The window counter advances by one without restarting while it is open, and it closes only after the full window. `corr_o` moves only in update cycles. A gain strobe always leads to fast mode. Fast mode never ends on a large error, and it never ends outside an evaluation. The bench's reference model is needed for the rest. It establishes the exact averaging and step values, the two-cycle latency, the rejection of codes outside the window, the four-line averaging, the saturation limits, the restart of the exit count and the precedence of a strobe over an exit.

// File: rtl/blk_clamp_pkg.sv
// Shared types for the black-level clamp loop.
// Assumes nothing beyond IEEE 1800-2017.
package blk_clamp_pkg;

    // Loop gain state of the feedback controller.
    typedef enum logic {
        LOOP_NORMAL = 1'b0,
        LOOP_FAST   = 1'b1
    } loop_mode_e;

endpackage

// File: rtl/blk_ob_window.sv
// Optical-black window averager.
// After an active edge of the optical-black pulse, this module sums the
// samples taken at clocks WIN_START .. WIN_START+WIN_LEN-1 and emits their
// mean as a one-cycle measurement.
// Assumes WIN_LEN is a power of two, WIN_START >= 1 and that the pulse is
// wider than two clocks. Edges that arrive while the window is open are ignored.
module blk_ob_window #(
    parameter int SAMPLE_W  = 12,
    parameter int WIN_START = 5,
    parameter int WIN_LEN   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                ob_i,
    input  logic                ob_inv_i,
    output logic                meas_vld_o,
    output logic [SAMPLE_W-1:0] meas_o
);
    localparam int WIN_END = WIN_START + WIN_LEN - 1;
    localparam int CNT_W   = $clog2(WIN_END + 1);
    localparam int LOG_LEN = $clog2(WIN_LEN);
    localparam int SUM_W   = SAMPLE_W + LOG_LEN;

    logic             ob_act, ob_prev;
    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum_q, sum_full;
    logic             start, in_win, at_end;

    assign ob_act   = ob_i ^ ob_inv_i;
    assign start    = ob_act & ~ob_prev & (cnt_q == '0);
    assign in_win   = (cnt_q >= CNT_W'(WIN_START));
    assign at_end   = (cnt_q == CNT_W'(WIN_END));
    assign sum_full = sum_q + SUM_W'(sample_i);

    // Remember the previous pulse level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ob_prev <= 1'b0;
        else        ob_prev <= ob_act;
    end

    // Position counter: 0 when idle, otherwise clocks since the edge.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start)         cnt_q <= CNT_W'(1);
        else if (at_end)        cnt_q <= '0;
        else if (cnt_q != '0)   cnt_q <= cnt_q + CNT_W'(1);
    end

    // Accumulate the samples that fall inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (at_end) sum_q <= '0;
        else if (in_win) sum_q <= sum_full;
    end

    // Emit the window mean one cycle after the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_vld_o <= 1'b0;
            meas_o     <= '0;
        end else begin
            meas_vld_o <= at_end;
            if (at_end) meas_o <= sum_full[SUM_W-1:LOG_LEN];
        end
    end

    // R4: an open window advances by one each clock, regardless of new edges.
    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !at_end) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R2: the window closes only after its full length.
    a_r2_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld_o |-> ($past(cnt_q) == CNT_W'(WIN_END)));

endmodule

// File: rtl/blk_line_avg.sv
// Line averager.
// Passes each line measurement straight through, or, when enabled, emits the
// mean of LINES consecutive measurements once every LINES lines.
// Assumes LINES is a power of two and at least 2. Clearing the enable drops
// any partial group.
module blk_line_avg #(
    parameter int SAMPLE_W = 12,
    parameter int LINES    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                avg_en_i,
    input  logic                meas_vld_i,
    input  logic [SAMPLE_W-1:0] meas_i,
    output logic                blk_vld_o,
    output logic [SAMPLE_W-1:0] blk_o
);
    localparam int LOG = $clog2(LINES);
    localparam int AW  = SAMPLE_W + LOG;

    logic [LOG-1:0] lc_q;
    logic [AW-1:0]  lsum_q, lsum_full;
    logic           grp_last;

    assign lsum_full = lsum_q + AW'(meas_i);
    assign grp_last  = (lc_q == LOG'(LINES - 1));

    // Collect measurements and release one black level per group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc_q      <= '0;
            lsum_q    <= '0;
            blk_vld_o <= 1'b0;
            blk_o     <= '0;
        end else begin
            blk_vld_o <= 1'b0;
            if (!avg_en_i) begin
                lc_q   <= '0;
                lsum_q <= '0;
                if (meas_vld_i) begin
                    blk_vld_o <= 1'b1;
                    blk_o     <= meas_i;
                end
            end else if (meas_vld_i) begin
                if (grp_last) begin
                    blk_vld_o <= 1'b1;
                    blk_o     <= lsum_full[AW-1:LOG];
                    lc_q      <= '0;
                    lsum_q    <= '0;
                end else begin
                    lc_q   <= lc_q + LOG'(1);
                    lsum_q <= lsum_full;
                end
            end
        end
    end

    // R11: an evaluation is only released right after a measurement.
    a_r11_out_after_meas: assert property (@(posedge clk) disable iff (!rst_n)
        blk_vld_o |-> $past(meas_vld_i));

endmodule

// File: rtl/blk_corr_loop.sv
// Correction integrator with fast-acquisition control.
// For each evaluated black level, this module forms the error against the
// programmed target, scales it into a step, and adds the step to a
// saturating signed correction. A gain-change strobe enables a multiplied
// step until the error has stayed within FAST_THRESH for a selected number
// of evaluations.
// Assumes that evaluations are at least two cycles apart.
module blk_corr_loop
    import blk_clamp_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int CORR_W      = 12,
    parameter int STEP_SHIFT  = 4,
    parameter int FAST_THRESH = 64,
    parameter int TGT_BASE    = 56,
    parameter int TGT_STEP    = 8,
    parameter int TGT_W       = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     blk_vld_i,
    input  logic [SAMPLE_W-1:0]      blk_i,
    input  logic [TGT_W-1:0]         target_sel_i,
    input  logic [1:0]               mult_sel_i,
    input  logic [1:0]               exit_sel_i,
    input  logic                     gain_chg_i,
    output logic signed [CORR_W-1:0] corr_o,
    output logic                     fast_o,
    output logic                     update_o
);
    localparam int EW = SAMPLE_W + 2;
    localparam int SW = EW + 4;
    localparam int AW = SW + 1;
    localparam logic signed [EW-1:0] THR_P  = EW'(FAST_THRESH);
    localparam logic signed [EW-1:0] THR_N  = -THR_P;
    localparam logic signed [AW-1:0] CMAX_A = AW'(2 ** (CORR_W - 1) - 1);
    localparam logic signed [AW-1:0] CMIN_A = -CMAX_A - AW'(1);

    loop_mode_e                mode_q;
    logic [3:0]                calm_q, lines_need;
    logic signed [EW-1:0]      tgt_s, blk_s, err_s, err_shr;
    logic signed [SW-1:0]      base_step, step_s;
    logic signed [AW-1:0]      sum_s;
    logic signed [CORR_W-1:0]  corr_next;
    logic                      err_big, calm_done;

    assign fast_o     = (mode_q == LOOP_FAST);
    assign tgt_s      = $signed(EW'(TGT_BASE + TGT_STEP * int'(target_sel_i)));
    assign blk_s      = $signed({2'b00, blk_i});
    assign err_s      = tgt_s - blk_s;
    assign err_big    = (err_s > THR_P) || (err_s < THR_N);
    assign lines_need = 4'd1 << exit_sel_i;
    assign calm_done  = ((calm_q + 4'd1) >= lines_need);

    // Scale the error into a step, multiplied while in fast mode.
    always_comb begin
        err_shr   = err_s >>> STEP_SHIFT;
        base_step = {{(SW - EW){err_shr[EW-1]}}, err_shr};
        step_s    = fast_o ? (base_step <<< (3'(mult_sel_i) + 3'd1)) : base_step;
    end

    // Add the step to the correction and clip to the signed range.
    always_comb begin
        sum_s = {{(AW - CORR_W){corr_o[CORR_W-1]}}, corr_o} + {step_s[SW-1], step_s};
        if (sum_s > CMAX_A)      corr_next = CMAX_A[CORR_W-1:0];
        else if (sum_s < CMIN_A) corr_next = CMIN_A[CORR_W-1:0];
        else                     corr_next = sum_s[CORR_W-1:0];
    end

    // Register the correction once per evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_o   <= '0;
            update_o <= 1'b0;
        end else begin
            update_o <= blk_vld_i;
            if (blk_vld_i) corr_o <= corr_next;
        end
    end

    // Enter fast mode on a gain change, and leave it after enough calm evaluations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= LOOP_NORMAL;
            calm_q <= '0;
        end else if (gain_chg_i) begin
            mode_q <= LOOP_FAST;
            calm_q <= '0;
        end else if (blk_vld_i && fast_o) begin
            if (err_big) begin
                calm_q <= '0;
            end else if (calm_done) begin
                mode_q <= LOOP_NORMAL;
                calm_q <= '0;
            end else begin
                calm_q <= calm_q + 4'd1;
            end
        end
    end

    // R6: the correction moves only in update cycles.
    a_r6_corr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> $stable(corr_o));

    // R8: a gain strobe always leads to fast mode.
    a_r8_fast_entry: assert property (@(posedge clk) disable iff (!rst_n)
        gain_chg_i |=> fast_o);

    // R9: a large error never ends fast mode.
    a_r9_stay_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_o && blk_vld_i && err_big) |=> fast_o);

    // R10: fast mode only ends at an evaluation.
    a_r10_exit_on_eval: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_o) |-> $past(blk_vld_i));

endmodule

// File: rtl/blk_clamp_loop.sv
// Top level of the black-level clamp loop.
// Chain: window averager -> optional four-line averager -> correction loop.
// Assumes all register-field inputs are static while a line is processed.
module blk_clamp_loop #(
    parameter int SAMPLE_W    = 12,
    parameter int CORR_W      = 12,
    parameter int WIN_START   = 5,
    parameter int WIN_LEN     = 8,
    parameter int AVG_LINES   = 4,
    parameter int STEP_SHIFT  = 4,
    parameter int FAST_THRESH = 64,
    parameter int TGT_BASE    = 56,
    parameter int TGT_STEP    = 8,
    parameter int TGT_W       = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SAMPLE_W-1:0]      sample_i,
    input  logic                     ob_pulse_i,
    input  logic                     ob_low_act_i,
    input  logic                     gain_chg_i,
    input  logic [TGT_W-1:0]         target_sel_i,
    input  logic [1:0]               fast_mult_sel_i,
    input  logic [1:0]               exit_lines_sel_i,
    input  logic                     avg4_en_i,
    output logic signed [CORR_W-1:0] corr_o,
    output logic                     fast_o,
    output logic                     update_o
);
    logic                meas_vld, blk_vld;
    logic [SAMPLE_W-1:0] meas, blk;

    blk_ob_window #(
        .SAMPLE_W  (SAMPLE_W),
        .WIN_START (WIN_START),
        .WIN_LEN   (WIN_LEN)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (sample_i),
        .ob_i       (ob_pulse_i),
        .ob_inv_i   (ob_low_act_i),
        .meas_vld_o (meas_vld),
        .meas_o     (meas)
    );

    blk_line_avg #(
        .SAMPLE_W (SAMPLE_W),
        .LINES    (AVG_LINES)
    ) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .avg_en_i   (avg4_en_i),
        .meas_vld_i (meas_vld),
        .meas_i     (meas),
        .blk_vld_o  (blk_vld),
        .blk_o      (blk)
    );

    blk_corr_loop #(
        .SAMPLE_W    (SAMPLE_W),
        .CORR_W      (CORR_W),
        .STEP_SHIFT  (STEP_SHIFT),
        .FAST_THRESH (FAST_THRESH),
        .TGT_BASE    (TGT_BASE),
        .TGT_STEP    (TGT_STEP),
        .TGT_W       (TGT_W)
    ) u_loop (
        .clk          (clk),
        .rst_n        (rst_n),
        .blk_vld_i    (blk_vld),
        .blk_i        (blk),
        .target_sel_i (target_sel_i),
        .mult_sel_i   (fast_mult_sel_i),
        .exit_sel_i   (exit_lines_sel_i),
        .gain_chg_i   (gain_chg_i),
        .corr_o       (corr_o),
        .fast_o       (fast_o),
        .update_o     (update_o)
    );

endmodule

// File: tb/blk_clamp_loop_test.sv
// Bench: a behavioural reference model is compared with the outputs on
// every clock, and directed scenarios add hand-computed checks.
module blk_clamp_loop_test;
    localparam int LINE = 30;

    logic               clk = 1'b0, rst_n = 1'b0;
    logic [11:0]        sample = '0;
    logic               ob_pulse = 1'b0, ob_low_act = 1'b0, gain_chg = 1'b0, avg4 = 1'b0;
    logic [4:0]         tsel = '0;
    logic [1:0]         msel = '0, xsel = '0;
    logic signed [11:0] corr_o;
    logic               fast_o, update_o;

    int  checks = 0, errors = 0;
    bit  fin = 1'b0;

    // Reference model state.
    int  m_corr, m_run, p_meas, p_blk, l_sum, l_n, pos;
    bit  m_fast, m_upd, m_prev, win_on;
    int  q[$];

    always #10 clk = ~clk;

    blk_clamp_loop uut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .ob_pulse_i(ob_pulse),
        .ob_low_act_i(ob_low_act), .gain_chg_i(gain_chg), .target_sel_i(tsel),
        .fast_mult_sel_i(msel), .exit_lines_sel_i(xsel), .avg4_en_i(avg4),
        .corr_o(corr_o), .fast_o(fast_o), .update_o(update_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model, advanced at each rising edge.
    always @(posedge clk) begin
        int e, st, na, s;
        bit act;
        if (!rst_n) begin
            m_corr = 0; m_run = 0; m_fast = 0; m_upd = 0; m_prev = 0; win_on = 0;
            p_meas = -1; p_blk = -1; l_sum = 0; l_n = 0; pos = 0; q.delete();
        end else begin
            m_upd = 0;
            e = 0;
            if (p_blk >= 0) begin
                e  = 56 + 8 * int'(tsel) - p_blk;
                st = e >>> 4;
                if (m_fast) st = st * (2 << msel);
                na = m_corr + st;
                m_corr = (na > 2047) ? 2047 : ((na < -2048) ? -2048 : na);
                m_upd = 1;
            end
            if (gain_chg) begin
                m_fast = 1; m_run = 0;
            end else if (p_blk >= 0 && m_fast) begin
                if (e > 64 || e < -64) m_run = 0;
                else begin
                    m_run++;
                    if (m_run >= (1 << xsel)) begin m_fast = 0; m_run = 0; end
                end
            end
            p_blk = -1;
            if (p_meas >= 0) begin
                if (avg4) begin
                    l_sum += p_meas; l_n++;
                    if (l_n == 4) begin p_blk = l_sum / 4; l_sum = 0; l_n = 0; end
                end else begin
                    l_sum = 0; l_n = 0; p_blk = p_meas;
                end
            end else if (!avg4) begin
                l_sum = 0; l_n = 0;
            end
            p_meas = -1;
            act = ob_pulse ^ ob_low_act;
            if (win_on) begin
                if (pos >= 5) q.push_back(int'(sample));
                if (pos == 12) begin
                    s = 0;
                    foreach (q[i]) s += q[i];
                    p_meas = s / 8; q.delete(); win_on = 0;
                end else pos++;
            end else if (act && !m_prev) begin
                win_on = 1; pos = 1;
            end
            m_prev = act;
        end
    end

    // Compare the outputs with the model on every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R6 corr vs model", int'(corr_o), m_corr);
            chk("R8 fast vs model", int'(fast_o), int'(m_fast));
            chk("R6 update vs model", int'(update_o), int'(m_upd));
        end
    end

    // One line: OB pulse at k=0, window codes base+k%3 (mean base+1), junk elsewhere.
    task automatic run_line(input int base, input int junk, input bit retrig,
                            input int strobe_k, output int n_upd, output int first_k);
        bit a;
        n_upd = 0; first_k = -1;
        for (int k = 0; k < LINE; k++) begin
            @(negedge clk);
            if (update_o) begin
                n_upd++;
                if (first_k < 0) first_k = k;
            end
            a = retrig ? (k < 3 || (k >= 4 && k < 7)) : (k < 4);
            ob_pulse = a ^ ob_low_act;
            sample   = (k >= 5 && k <= 12) ? 12'(base + k % 3) : 12'(junk);
            gain_chg = (k == strobe_k);
        end
    endtask

    task automatic pulse_gain();
        @(negedge clk); gain_chg = 1'b1;
        @(negedge clk); gain_chg = 1'b0;
    endtask

    initial begin
        int n, fk, c0;
        repeat (3) @(negedge clk);
        // R1: outputs held during reset.
        chk("R1 corr in reset", int'(corr_o), 0);
        chk("R1 fast in reset", int'(fast_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 corr after reset", int'(corr_o), 0);
        chk("R1 update after reset", int'(update_o), 0);

        // R2, R5, R6: target 56, measured 24, step 2, junk codes ignored.
        tsel = 5'd0;
        run_line(23, 4095, 0, -1, n, fk);
        chk("R2 single update per line", n, 1);
        chk("R6 update latency slot", fk, 15);
        chk("R2 corr after line", int'(corr_o), 2);

        // R5: target 128, measured 128, zero error.
        tsel = 5'd9;
        run_line(127, 0, 0, -1, n, fk);
        chk("R5 zero error keeps corr", int'(corr_o), 2);

        // R3: active-low pulse.
        @(negedge clk); ob_low_act = 1'b1; ob_pulse = 1'b1;
        tsel = 5'd0;
        run_line(23, 4095, 0, -1, n, fk);
        chk("R3 active-low update", n, 1);
        chk("R3 corr after line", int'(corr_o), 4);
        @(negedge clk); ob_low_act = 1'b0; ob_pulse = 1'b0;

        // R4: second edge inside the open window.
        run_line(23, 4095, 1, -1, n, fk);
        chk("R4 retrigger one update", n, 1);
        chk("R4 corr after line", int'(corr_o), 6);

        // R8, R10: x16 step, exit after one calm evaluation.
        msel = 2'd3; xsel = 2'd0;
        pulse_gain();
        chk("R8 fast after strobe", int'(fast_o), 1);
        run_line(23, 0, 0, -1, n, fk);
        chk("R8 multiplied step", int'(corr_o), 38);
        chk("R10 exit after one calm", int'(fast_o), 0);

        // R9, R10: x2 step, two calm evaluations, restart on a large error.
        msel = 2'd0; xsel = 2'd1;
        pulse_gain();
        run_line(23, 0, 0, -1, n, fk);
        chk("R10 one calm not enough", int'(fast_o), 1);
        chk("R8 x2 step", int'(corr_o), 42);
        run_line(200, 0, 0, -1, n, fk);
        chk("R9 large error stays fast", int'(fast_o), 1);
        run_line(23, 0, 0, -1, n, fk);
        chk("R9 count restarted", int'(fast_o), 1);
        run_line(23, 0, 0, -1, n, fk);
        chk("R10 exit after two calm", int'(fast_o), 0);

        // R12: strobe coincides with an exiting evaluation.
        xsel = 2'd0;
        pulse_gain();
        run_line(23, 0, 0, 14, n, fk);
        chk("R12 strobe wins over exit", int'(fast_o), 1);
        run_line(23, 0, 0, -1, n, fk);
        chk("R10 later exit", int'(fast_o), 0);

        // R11: four-line averaging, measurements 16,24,32,40 -> 28, step 1.
        avg4 = 1'b1;
        c0 = int'(corr_o);
        begin
            int tot = 0;
            for (int i = 0; i < 4; i++) begin
                run_line(15 + 8 * i, 0, 0, -1, n, fk);
                tot += n;
                if (i < 3) chk("R11 no change mid group", int'(corr_o), c0);
            end
            chk("R11 one update per group", tot, 1);
        end
        chk("R11 averaged step", int'(corr_o), c0 + 1);
        avg4 = 1'b0;

        // R7: saturation at both limits.
        tsel = 5'd31; msel = 2'd3; xsel = 2'd0;
        pulse_gain();
        for (int i = 0; i < 10; i++) run_line(0, 0, 0, -1, n, fk);
        chk("R7 upper limit", int'(corr_o), 2047);
        tsel = 5'd0;
        for (int i = 0; i < 2; i++) run_line(4093, 0, 0, -1, n, fk);
        chk("R7 lower limit", int'(corr_o), -2048);

        repeat (5) @(negedge clk);
        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #4000000;
        if (!fin) begin
            fin = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule